// File: doc/BRIEF.md
# Software Event Trigger Register

This block holds one pending flag per DMA event channel and lets a processor raise any of those events by writing ones through a simple register write port. A raised event stays pending until the downstream request logic reports, through a one-cycle accept pulse carrying the event's index, that the transfer request for it has been taken. While flags are pending, a fixed-priority selector offers the lowest-numbered one as the next request to submit.

A software trigger always counts as a valid event. No enable mask gates it, and software has no way to withdraw it. A trigger that hits a flag that is already pending cannot be queued a second time. It is recorded instead in a sticky missed-event register, which software clears with write-one-to-clear. If a software set and a hardware clear reach the same flag in one cycle, the set wins.

Top module: `sw_event_trigger`

## Requirements
- R1: After reset, the pending vector `pend_rd`, the missed vector `miss_rd` and `req_valid` are all zero.
- R2: A cycle with `set_en` high sets every pending bit whose `set_data` bit is 1, visible on `pend_rd` one clock later. Bits written with 0 keep their value, so a write of all zeros changes nothing.
- R3: A pending bit is cleared only by an accept pulse (`acc_valid` high, `acc_idx` equal to the bit number), visible one clock later. Software writes never clear a pending bit.
- R4: When a set and an accept reach the same bit in one cycle, the bit is pending afterwards, whatever its earlier state.
- R5: In the R4 case, if the bit was already pending before the cycle, its missed bit is set one clock later. If it was idle, the missed bit is unchanged.
- R6: A set of a bit that is already pending, with no accept for it, sets its missed bit one clock later. A set of an idle bit leaves the missed bit at 0.
- R7: Missed bits are sticky. A cycle with `miss_clr_en` high clears the missed bits whose `miss_clr_data` bit is 1. Zeros in `miss_clr_data` have no effect.
- R8: When a new miss and a missed-bit clear hit the same bit in one cycle, the missed bit is 1 afterwards.
- R9: `req_valid` is 1 exactly when any pending bit is set, and `req_idx` then gives the lowest-numbered pending bit.
- R10: An accept whose index names a bit that is not pending changes neither `pend_rd` nor `miss_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| set_en | input | 1 | Write strobe of the trigger register |
| set_data | input | 32 | Write data, where a 1 raises the matching event |
| miss_clr_en | input | 1 | Write strobe of the missed-event clear port |
| miss_clr_data | input | 32 | Write data, where a 1 clears the matching missed bit |
| acc_valid | input | 1 | One-cycle pulse: a transfer request was accepted |
| acc_idx | input | 5 | Index of the accepted event |
| pend_rd | output | 32 | Current pending bits (side-effect-free readback) |
| miss_rd | output | 32 | Current missed-event bits |
| req_valid | output | 1 | At least one event is pending |
| req_idx | output | 5 | Lowest-numbered pending event |

## Verification
The hardest situation to reach is a cycle in which an accept pulse and a software write name the same bit that is already pending, because only that cycle tests both set-wins-over-clear and the loss of an event. The bench builds that state first with a single write. It then drives the write and an accept with the same index in one cycle, and checks that the pending bit survives and the missed bit rises. A second directed case pairs a new miss with a missed-bit clear in the same cycle to confirm the miss takes priority.

// File: rtl/sw_event_trigger_pkg.sv
package sw_event_trigger_pkg;
  localparam int unsigned EVT_NUM = 32;
  localparam int unsigned EVT_IDX_W = $clog2(EVT_NUM);
  typedef logic [EVT_NUM-1:0] evt_vec_t;
endpackage

// File: rtl/swtrig_pend_bank.sv
module swtrig_pend_bank #(
  parameter int unsigned N = 32,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  set_vec,
  input  logic          acc_valid,
  input  logic [IW-1:0] acc_idx,
  output logic [N-1:0]  pend_q,
  output logic [N-1:0]  lost_vec
);
  logic [N-1:0] clr_vec;
  logic [N-1:0] pend_d;
  logic         pend_ce;

  for (genvar i = 0; i < N; i++) begin : g_clr
    assign clr_vec[i] = acc_valid && (acc_idx == IW'(i));
  end

  always_comb begin
    pend_d   = (pend_q & ~clr_vec) | set_vec;
    lost_vec = set_vec & pend_q;
    pend_ce  = (|set_vec) | acc_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_ce) pend_q <= pend_d;
  end
endmodule

// File: rtl/swtrig_miss_log.sv
module swtrig_miss_log #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lost_vec,
  input  logic [N-1:0] wclr_vec,
  output logic [N-1:0] miss_q
);
  logic [N-1:0] miss_d;
  logic         miss_ce;

  always_comb begin
    miss_d  = (miss_q & ~wclr_vec) | lost_vec;
    miss_ce = (|lost_vec) | (|wclr_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       miss_q <= '0;
    else if (miss_ce) miss_q <= miss_d;
  end
endmodule

// File: rtl/swtrig_prio_sel.sv
module swtrig_prio_sel #(
  parameter int unsigned N = 32,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_vec,
  output logic          any_vld,
  output logic [IW-1:0] first_idx
);
  always_comb begin
    first_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_vec[i]) first_idx = IW'(i);
    end
    any_vld = |req_vec;
  end
endmodule

// File: rtl/sw_event_trigger.sv
module sw_event_trigger
  import sw_event_trigger_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en,
  input  logic [EVT_NUM-1:0]   set_data,
  input  logic                 miss_clr_en,
  input  logic [EVT_NUM-1:0]   miss_clr_data,
  input  logic                 acc_valid,
  input  logic [EVT_IDX_W-1:0] acc_idx,
  output logic [EVT_NUM-1:0]   pend_rd,
  output logic [EVT_NUM-1:0]   miss_rd,
  output logic                 req_valid,
  output logic [EVT_IDX_W-1:0] req_idx
);
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  evt_vec_t   set_vec;
  evt_vec_t   wclr_vec;
  evt_vec_t   lost_vec;
  evt_vec_t   pend_q;
  evt_vec_t   miss_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  always_comb begin
    set_vec  = set_data & {EVT_NUM{set_en}};
    wclr_vec = miss_clr_data & {EVT_NUM{miss_clr_en}};
  end

  swtrig_pend_bank #(.N(EVT_NUM)) u_pend (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_vec  (set_vec),
    .acc_valid(acc_valid),
    .acc_idx  (acc_idx),
    .pend_q   (pend_q),
    .lost_vec (lost_vec)
  );

  swtrig_miss_log #(.N(EVT_NUM)) u_miss (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .lost_vec(lost_vec),
    .wclr_vec(wclr_vec),
    .miss_q  (miss_q)
  );

  swtrig_prio_sel #(.N(EVT_NUM)) u_sel (
    .req_vec  (pend_q),
    .any_vld  (req_valid),
    .first_idx(req_idx)
  );

  assign pend_rd = pend_q;
  assign miss_rd = miss_q;
endmodule

// File: rtl/sw_event_trigger_chk.sv
module sw_event_trigger_chk
  import sw_event_trigger_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 set_en,
  input logic [EVT_NUM-1:0]   set_data,
  input logic                 miss_clr_en,
  input logic [EVT_NUM-1:0]   miss_clr_data,
  input logic                 acc_valid,
  input logic [EVT_IDX_W-1:0] acc_idx,
  input logic [EVT_NUM-1:0]   pend_rd,
  input logic [EVT_NUM-1:0]   miss_rd,
  input logic                 req_valid,
  input logic [EVT_IDX_W-1:0] req_idx
);
  logic     armed_q;
  evt_vec_t sw_set;
  evt_vec_t hw_clr;
  evt_vec_t sw_mclr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  always_comb begin
    sw_set  = set_en ? set_data : '0;
    hw_clr  = acc_valid ? (evt_vec_t'(1) << acc_idx) : '0;
    sw_mclr = miss_clr_en ? miss_clr_data : '0;
  end

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> ((pend_rd & $past(sw_set)) == $past(sw_set))); // R2

  AST_ONLY_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> ((($past(pend_rd) & ~pend_rd) & ~$past(hw_clr)) == '0)); // R3

  AST_DUP_LOGGED: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> ((miss_rd & $past(sw_set & pend_rd)) == $past(sw_set & pend_rd))); // R6

  AST_MISS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> ((($past(miss_rd) & ~miss_rd) & ~$past(sw_mclr)) == '0)); // R7

  AST_REQ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid == (pend_rd != '0)); // R9

  AST_REQ_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (pend_rd[req_idx] &&
                   ((pend_rd & ((evt_vec_t'(1) << req_idx) - evt_vec_t'(1))) == '0))); // R9
endmodule

bind sw_event_trigger sw_event_trigger_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .set_en       (set_en),
  .set_data     (set_data),
  .miss_clr_en  (miss_clr_en),
  .miss_clr_data(miss_clr_data),
  .acc_valid    (acc_valid),
  .acc_idx      (acc_idx),
  .pend_rd      (pend_rd),
  .miss_rd      (miss_rd),
  .req_valid    (req_valid),
  .req_idx      (req_idx)
);

// File: tb/sw_event_trigger_tb_top.sv
module sw_event_trigger_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        set_en;
  logic [31:0] set_data;
  logic        miss_clr_en;
  logic [31:0] miss_clr_data;
  logic        acc_valid;
  logic [4:0]  acc_idx;
  logic [31:0] pend_rd;
  logic [31:0] miss_rd;
  logic        req_valid;
  logic [4:0]  req_idx;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  sw_event_trigger dut_i (
    .clk(clk), .rst_n(rst_n), .set_en(set_en), .set_data(set_data),
    .miss_clr_en(miss_clr_en), .miss_clr_data(miss_clr_data),
    .acc_valid(acc_valid), .acc_idx(acc_idx), .pend_rd(pend_rd),
    .miss_rd(miss_rd), .req_valid(req_valid), .req_idx(req_idx)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    set_en = 1'b0; set_data = '0; miss_clr_en = 1'b0; miss_clr_data = '0;
    acc_valid = 1'b0; acc_idx = '0;
  endtask

  // called at a falling edge with inputs driven; returns at the next falling edge
  task automatic step();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_set(input logic [31:0] d);
    set_en = 1'b1; set_data = d; step();
  endtask

  task automatic do_acc(input logic [4:0] i);
    acc_valid = 1'b1; acc_idx = i; step();
  endtask

  task automatic do_mclr(input logic [31:0] d);
    miss_clr_en = 1'b1; miss_clr_data = d; step();
  endtask

  task automatic t_reset();
    chk("R1 pend", pend_rd, 32'h0);
    chk("R1 miss", miss_rd, 32'h0);
    chk("R1 req_valid", {31'b0, req_valid}, 32'h0);
  endtask

  task automatic t_set_and_zero();
    do_set(32'h0000_0500);
    chk("R2 set", pend_rd, 32'h0000_0500);
    chk("R9 idx", {27'b0, req_idx}, 32'd8);
    do_set(32'h0);
    chk("R2 zero write", pend_rd, 32'h0000_0500);
    chk("R2 no miss", miss_rd, 32'h0);
  endtask

  task automatic t_accept();
    do_acc(5'd8);
    chk("R3 clear", pend_rd, 32'h0000_0400);
    chk("R9 idx next", {27'b0, req_idx}, 32'd10);
    do_acc(5'd3);
    chk("R10 idle pend", pend_rd, 32'h0000_0400);
    chk("R10 idle miss", miss_rd, 32'h0);
    do_acc(5'd10);
    chk("R3 empty", pend_rd, 32'h0);
    chk("R9 valid low", {31'b0, req_valid}, 32'h0);
  endtask

  task automatic t_prio();
    do_set(32'h8000_0000);
    chk("R9 top idx", {27'b0, req_idx}, 32'd31);
    do_set(32'h0001_0000);
    chk("R9 lower idx", {27'b0, req_idx}, 32'd16);
    do_acc(5'd16);
    chk("R9 back to top", {27'b0, req_idx}, 32'd31);
    do_acc(5'd31);
    chk("R9 drained", {31'b0, req_valid}, 32'h0);
  endtask

  task automatic t_dup();
    do_set(32'h0000_0020);
    chk("R6 fresh no miss", miss_rd, 32'h0);
    do_set(32'h0000_0020);
    chk("R6 dup miss", miss_rd, 32'h0000_0020);
    chk("R6 still pending", pend_rd, 32'h0000_0020);
  endtask

  task automatic t_miss_clr();
    do_mclr(32'h0);
    chk("R7 zero clear", miss_rd, 32'h0000_0020);
    do_mclr(32'h0000_0020);
    chk("R7 clear", miss_rd, 32'h0);
    chk("R3 clr port no effect on pend", pend_rd, 32'h0000_0020);
    do_acc(5'd5);
    chk("R3 drained", pend_rd, 32'h0);
  endtask

  task automatic t_set_wins();
    do_set(32'h0000_0004);
    set_en = 1'b1; set_data = 32'h0000_0004; acc_valid = 1'b1; acc_idx = 5'd2; step();
    chk("R4 set wins", pend_rd, 32'h0000_0004);
    chk("R5 lost event", miss_rd, 32'h0000_0004);
    do_mclr(32'hFFFF_FFFF);
    do_acc(5'd2);
    chk("R3 drained 2", pend_rd, 32'h0);
    set_en = 1'b1; set_data = 32'h0000_0080; acc_valid = 1'b1; acc_idx = 5'd7; step();
    chk("R4 idle set wins", pend_rd, 32'h0000_0080);
    chk("R5 idle no miss", miss_rd, 32'h0);
    do_acc(5'd7);
  endtask

  task automatic t_miss_vs_clr();
    do_set(32'h0000_0001);
    set_en = 1'b1; set_data = 32'h0000_0001;
    miss_clr_en = 1'b1; miss_clr_data = 32'h0000_0001; step();
    chk("R8 miss beats clear", miss_rd, 32'h0000_0001);
    do_mclr(32'h0000_0001);
    chk("R7 cleared", miss_rd, 32'h0);
    do_acc(5'd0);
    chk("R3 final", pend_rd, 32'h0);
  endtask

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_set_and_zero();
    t_accept();
    t_prio();
    t_dup();
    t_miss_clr();
    t_set_wins();
    t_miss_vs_clr();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule